// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the serial front end of a byte-wide nonvolatile memory. A host talks to it over a four-wire SPI link in clock mode 0 or mode 3. Each time chip select goes low, the first byte is taken as a command. The engine then collects a three-byte address, moves data bytes to or from an internal array port, reads or writes a single status byte, or streams a fixed identification sequence. When chip select rises, the command ends. The serial pins are sampled in a faster system clock domain through two-flop synchronisers, and every action comes from detected edges of the synchronised serial clock.

The engine makes no protection decisions. A separate protection unit supplies two level inputs that permit array writes and status writes, holds the write-enable latch, and supplies the status byte. The engine tells that unit when a latch-set, latch-clear or sleep command has arrived. The serial output comes as a data bit and a separate drive enable, and the pad tri-state sits outside the block. The system clock must run at least four times as fast as the serial clock, with each serial clock phase lasting at least two system clock cycles.

Top module: `spi_mem_cmd_engine`

## Requirements
- R1: Input bits are taken on serial clock rising edges and output bits change only after falling edges, most significant bit first. The engine works in mode 0 (clock low when selected) and in mode 3 (clock high when selected, falling once before the first rising edge).
- R2: Command codes are 06h latch set, 04h latch clear, 05h status read, 01h status write, 03h array read, 0Bh fast array read, 02h array write, B9h sleep and 9Fh identification read. Any other code is unknown.
- R3: Only the first byte after chip select falls is decoded. Every later byte in the same selection is treated as an operand of that command or ignored, and is never decoded as a command.
- R4: Array read and array write take three address bytes. The low 18 bits form the start address and the upper 6 bits are discarded. Read data for the start address is driven from the falling edge after the last address bit, and each later byte comes from the next address.
- R5: The address counter steps by one after every data byte and wraps from 3FFFFh to 00000h.
- R6: In an array write, each data byte is committed on its 8th rising edge as a single mem_we cycle, at the current address with that byte, and only when mem_wr_allow is high. A byte cut short by chip select rising is discarded.
- R7: A fast array read places one dummy byte after the address. Its content is ignored and the output stays undriven during it. After that it behaves like an array read.
- R8: The identification read returns six bytes of 7Fh, then C2h, then 25h, then 00h. It keeps returning 00h after those nine bytes.
- R9: A status read returns stat_rdata in every byte. A status write raises stat_we for one cycle with the first data byte, only when stat_wr_allow is high. Further bytes in that selection have no effect.
- R10: wel_set pulses for one cycle when 06h completes, and wel_clr pulses for one cycle when 04h completes. wel_clr also pulses once after chip select rises if an array or status write was committed during that selection.
- R11: After a sleep command, sleep_req pulses for one cycle only after chip select rises.
- R12: spi_miso_oe is high only during array-read data, status-read or identification bytes. It stays low for unknown commands and falls within four system clocks after chip select rises.
- R13: After reset, spi_miso_oe, mem_rd, mem_we, stat_we, wel_set, wel_clr and sleep_req are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso |
| mem_addr | output | 18 | Array byte address |
| mem_rd | output | 1 | Array read strobe; data is expected on mem_rdata on the next cycle |
| mem_rdata | input | 8 | Array read data |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_wr_allow | input | 1 | Protection unit permits writing mem_addr |
| stat_rdata | input | 8 | Status byte returned by status read |
| stat_we | output | 1 | Status write strobe |
| stat_wdata | output | 8 | Status write data |
| stat_wr_allow | input | 1 | Protection unit permits a status write |
| wel_set | output | 1 | Latch-set command pulse |
| wel_clr | output | 1 | Latch-clear pulse (command or completed write) |
| sleep_req | output | 1 | Sleep entry pulse at end of selection |

## Verification
A wrong bit counter or phase shows up in the very next byte. Either read data is shifted by a bit, or the output enable rises during address or dummy bytes, which the host sees within eight serial clocks. A wrong address counter appears as the wrong byte on the second data byte of a burst, and at the 3FFFFh boundary as a jump to a nonzero address. A lost per-selection flag appears only when chip select rises, as a missing or extra wel_clr or sleep_req pulse, so the tests read those strobes right after the deselect.

// File: rtl/spimc_pkg.sv
// Shared constants and types for the SPI memory command engine.
// Assumes byte-wide serial transfers and fixed one-byte command codes.
package spimc_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD   = 8'h05;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;
    localparam logic [7:0] OP_ARR_RD    = 8'h03;
    localparam logic [7:0] OP_ARR_FRD   = 8'h0B;
    localparam logic [7:0] OP_ARR_WR    = 8'h02;
    localparam logic [7:0] OP_SLEEP     = 8'hB9;
    localparam logic [7:0] OP_IDENT     = 8'h9F;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_RDATA,
        PH_WDATA,
        PH_SRD,
        PH_SWR,
        PH_IDENT,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        AC_READ,
        AC_FAST,
        AC_WRITE
    } acc_e;

endpackage

// File: rtl/spimc_sync.sv
// Two-flop synchroniser plus a delayed copy for edge detection, one lane per bit.
// Assumes inputs are asynchronous to clk; RST_VAL is the idle level of each lane.
module spimc_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);

    for (genvar i = 0; i < W; i++) begin : g_lane
        logic s1, s2, s3;
        // Metastability filter followed by one delay stage for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
                s3 <= RST_VAL[i];
            end else begin
                s1 <= din[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign lvl[i] = s2;
        assign prv[i] = s3;
    end

endmodule

// File: rtl/spimc_rx.sv
// Serial receive shifter: counts bits of the current byte and assembles it MSB first.
// Assumes rise pulses come from the synchronised serial clock; clr holds it idle.
module spimc_rx import spimc_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rise,
    input  logic              din,
    output logic [2:0]        bit_cnt,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);

    logic [BYTE_W-2:0] sh_q;

    // Shift one bit per rising edge; the counter wraps every byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh_q    <= '0;
            bit_cnt <= '0;
        end else if (rise) begin
            sh_q    <= {sh_q[BYTE_W-3:0], din};
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    assign byte_done = rise && (bit_cnt == 3'd7);
    assign rx_byte   = {sh_q, din};

endmodule

// File: rtl/spimc_tx.sv
// Serial transmit shifter: on the first falling edge of a byte it loads the source
// byte and drives its MSB, then one further bit per falling edge.
// Assumes src is valid by the first falling edge of each transmitted byte.
module spimc_tx import spimc_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              fall,
    input  logic              tx_en,
    input  logic [2:0]        bit_cnt,
    input  logic [BYTE_W-1:0] src,
    output logic              miso,
    output logic              oe
);

    logic [BYTE_W-1:0] sh_q;

    // Output bit and drive enable; deselect drops the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            miso <= 1'b0;
            oe   <= 1'b0;
        end else if (!sel) begin
            oe   <= 1'b0;
        end else if (fall && tx_en) begin
            oe <= 1'b1;
            if (bit_cnt == 3'd0) begin
                miso <= src[BYTE_W-1];
                sh_q <= {src[BYTE_W-2:0], 1'b0};
            end else begin
                miso <= sh_q[BYTE_W-1];
                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spi_mem_cmd_engine.sv
// SPI slave command engine for a byte-organised memory array.
// Decodes one command per chip-select window, sequences address, data, status and
// identification bytes, and issues array and status strobes.
// Assumes clk >= 4x serial clock with each serial phase >= 2 clk cycles, and an
// array port whose read data is valid the cycle after mem_rd.
module spi_mem_cmd_engine import spimc_pkg::*; #(
    parameter int          ADDR_W    = 18,
    parameter int          ID_CONT_N = 6,
    parameter logic [7:0]  ID_CONT   = 8'h7F,
    parameter logic [7:0]  ID_MFR    = 8'hC2,
    parameter logic [7:0]  ID_DEV0   = 8'h25,
    parameter logic [7:0]  ID_DEV1   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic              mem_wr_allow,
    input  logic [7:0]        stat_rdata,
    output logic              stat_we,
    output logic [7:0]        stat_wdata,
    input  logic              stat_wr_allow,
    output logic              wel_set,
    output logic              wel_clr,
    output logic              sleep_req
);

    localparam int ADDR_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;
    localparam int ASH_W      = ADDR_BYTES * BYTE_W;
    localparam int ABW        = $clog2(ADDR_BYTES + 1);
    localparam int ID_LEN     = ID_CONT_N + 3;
    localparam int IDX_W      = $clog2(ID_LEN + 1);

    // Synchronised pins: lane 0 chip select, lane 1 clock, lane 2 data.
    logic [2:0] pin_lvl, pin_prv;
    spimc_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_mosi, spi_sck, spi_cs_n}),
        .lvl   (pin_lvl),
        .prv   (pin_prv)
    );

    logic sel, cs_fall_ev, cs_rise_ev, sck_rise, sck_fall;
    assign sel        = !pin_lvl[0];
    assign cs_fall_ev = !pin_lvl[0] && pin_prv[0];
    assign cs_rise_ev = pin_lvl[0] && !pin_prv[0];
    assign sck_rise   = sel && pin_lvl[1] && !pin_prv[1];
    assign sck_fall   = sel && !pin_lvl[1] && pin_prv[1];

    logic [2:0]        bit_cnt;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    spimc_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!sel),
        .rise      (sck_rise),
        .din       (pin_lvl[2]),
        .bit_cnt   (bit_cnt),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    phase_e           phase_q;
    acc_e             acc_q;
    logic [ASH_W-1:0] addr_q;
    logic [ABW-1:0]   abyte_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       wdata_q;
    logic             rd_pend, we_pend, sw_pend;
    logic             set_q, clr_q, slp_q, sleep_arm, wrote_q;
    logic             commit;
    logic [ASH_W-1:0] addr_inc;
    logic [7:0]       id_byte, tx_src;
    logic             tx_en;

    // Next sequential address, wrapping inside the used address width.
    always_comb begin
        addr_inc = '0;
        addr_inc[ADDR_W-1:0] = addr_q[ADDR_W-1:0] + {{(ADDR_W-1){1'b0}}, 1'b1};
    end

    // Identification byte for the current byte index.
    always_comb begin
        if (int'(idx_q) < ID_CONT_N)       id_byte = ID_CONT;
        else if (int'(idx_q) == ID_CONT_N) id_byte = ID_MFR;
        else if (int'(idx_q) == ID_CONT_N + 1) id_byte = ID_DEV0;
        else if (int'(idx_q) == ID_CONT_N + 2) id_byte = ID_DEV1;
        else                               id_byte = 8'h00;
    end

    // Source byte and drive permission for the transmit shifter.
    always_comb begin
        tx_en  = 1'b0;
        tx_src = 8'h00;
        case (phase_q)
            PH_RDATA: begin tx_en = 1'b1; tx_src = mem_rdata;  end
            PH_SRD:   begin tx_en = 1'b1; tx_src = stat_rdata; end
            PH_IDENT: begin tx_en = 1'b1; tx_src = id_byte;    end
            default:  ;
        endcase
    end

    assign commit = (we_pend && mem_wr_allow) || (sw_pend && stat_wr_allow);

    // Command sequencer: phase, address counter, strobes and per-window flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            acc_q     <= AC_READ;
            addr_q    <= '0;
            abyte_q   <= '0;
            idx_q     <= '0;
            wdata_q   <= '0;
            rd_pend   <= 1'b0;
            we_pend   <= 1'b0;
            sw_pend   <= 1'b0;
            set_q     <= 1'b0;
            clr_q     <= 1'b0;
            slp_q     <= 1'b0;
            sleep_arm <= 1'b0;
            wrote_q   <= 1'b0;
        end else begin
            rd_pend <= 1'b0;
            we_pend <= 1'b0;
            sw_pend <= 1'b0;
            set_q   <= 1'b0;
            clr_q   <= 1'b0;
            slp_q   <= 1'b0;
            if (we_pend) addr_q <= addr_inc;
            if (commit)  wrote_q <= 1'b1;
            if (cs_rise_ev) begin
                slp_q <= sleep_arm;
                clr_q <= wrote_q;
            end
            if (!sel) begin
                phase_q   <= PH_IDLE;
                sleep_arm <= 1'b0;
                wrote_q   <= 1'b0;
            end else if (cs_fall_ev) begin
                phase_q <= PH_OPC;
            end else if (byte_done) begin
                case (phase_q)
                    PH_OPC: begin
                        case (rx_byte)
                            OP_LATCH_SET: begin set_q <= 1'b1; phase_q <= PH_DONE; end
                            OP_LATCH_CLR: begin clr_q <= 1'b1; phase_q <= PH_DONE; end
                            OP_STAT_RD:   phase_q <= PH_SRD;
                            OP_STAT_WR:   phase_q <= PH_SWR;
                            OP_ARR_RD:    begin acc_q <= AC_READ;  abyte_q <= '0; phase_q <= PH_ADDR; end
                            OP_ARR_FRD:   begin acc_q <= AC_FAST;  abyte_q <= '0; phase_q <= PH_ADDR; end
                            OP_ARR_WR:    begin acc_q <= AC_WRITE; abyte_q <= '0; phase_q <= PH_ADDR; end
                            OP_SLEEP:     begin sleep_arm <= 1'b1; phase_q <= PH_DONE; end
                            OP_IDENT:     begin idx_q <= '0; phase_q <= PH_IDENT; end
                            default:      phase_q <= PH_DONE;
                        endcase
                    end
                    PH_ADDR: begin
                        addr_q  <= {addr_q[ASH_W-BYTE_W-1:0], rx_byte};
                        abyte_q <= abyte_q + 1'b1;
                        if (abyte_q == ABW'(ADDR_BYTES - 1)) begin
                            case (acc_q)
                                AC_FAST:  phase_q <= PH_DUMMY;
                                AC_WRITE: phase_q <= PH_WDATA;
                                default:  begin phase_q <= PH_RDATA; rd_pend <= 1'b1; end
                            endcase
                        end
                    end
                    PH_DUMMY: begin
                        phase_q <= PH_RDATA;
                        rd_pend <= 1'b1;
                    end
                    PH_RDATA: begin
                        addr_q  <= addr_inc;
                        rd_pend <= 1'b1;
                    end
                    PH_WDATA: begin
                        wdata_q <= rx_byte;
                        we_pend <= 1'b1;
                    end
                    PH_SWR: begin
                        wdata_q <= rx_byte;
                        sw_pend <= 1'b1;
                        phase_q <= PH_DONE;
                    end
                    PH_IDENT: begin
                        if (int'(idx_q) != ID_LEN) idx_q <= idx_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    spimc_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .fall    (sck_fall),
        .tx_en   (tx_en),
        .bit_cnt (bit_cnt),
        .src     (tx_src),
        .miso    (spi_miso),
        .oe      (spi_miso_oe)
    );

    assign mem_addr   = addr_q[ADDR_W-1:0];
    assign mem_rd     = rd_pend;
    assign mem_we     = we_pend && mem_wr_allow;
    assign mem_wdata  = wdata_q;
    assign stat_we    = sw_pend && stat_wr_allow;
    assign stat_wdata = wdata_q;
    assign wel_set    = set_q;
    assign wel_clr    = clr_q;
    assign sleep_req  = slp_q;

endmodule

// File: rtl/spimc_check.sv
// Protocol checker for the SPI memory command engine, bound to the top module.
// Assumes the same clock and synchronous active-low reset as the engine.
module spimc_check (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_miso_oe,
    input logic mem_rd,
    input logic mem_we,
    input logic stat_we,
    input logic wel_set,
    input logic wel_clr,
    input logic sleep_req
);

    logic [2:0] hi_cnt;

    // Saturating count of consecutive cycles with chip select high.
    always_ff @(posedge clk) begin
        if (!rst_n)              hi_cnt <= '0;
        else if (!spi_cs_n)      hi_cnt <= '0;
        else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
    end

    p_oe_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= 3'd4) |-> !spi_miso_oe);

    p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_rd_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));

    p_swe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |=> !stat_we);

    p_latch_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wel_set && wel_clr));

    p_sleep_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !sleep_req);

    p_sleep_desel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> spi_cs_n);

endmodule

bind spi_mem_cmd_engine spimc_check u_spimc_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .mem_rd      (mem_rd),
    .mem_we      (mem_we),
    .stat_we     (stat_we),
    .wel_set     (wel_set),
    .wel_clr     (wel_clr),
    .sleep_req   (sleep_req)
);

// File: tb/spi_mem_cmd_engine_bench.sv
// Directed bench: acts as SPI host, models the array and protection inputs.
module spi_mem_cmd_engine_bench;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic        miso, miso_oe;
    logic [17:0] mem_addr;
    logic        mem_rd, mem_we, stat_we;
    logic [7:0]  mem_rdata, mem_wdata, stat_wdata;
    logic        mem_wr_allow = 1'b1, stat_wr_allow = 1'b1;
    logic [7:0]  stat_rdata = 8'h4C;
    logic        wel_set, wel_clr, sleep_req;

    int n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    spi_mem_cmd_engine u_spi_mem_cmd_engine (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_wr_allow(mem_wr_allow), .stat_rdata(stat_rdata), .stat_we(stat_we),
        .stat_wdata(stat_wdata), .stat_wr_allow(stat_wr_allow), .wel_set(wel_set),
        .wel_clr(wel_clr), .sleep_req(sleep_req)
    );

    // Array model (low 8 address bits) and strobe monitor.
    logic [7:0]  bmem [0:255];
    logic        mon_clr = 1'b0;
    int          n_we, n_rd, n_swe, n_set, n_clr, n_slp, n_oe;
    logic [17:0] wa [0:7];
    logic [7:0]  wd [0:7];
    logic [7:0]  swd;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'(i) ^ 8'h5A;
            mem_rdata <= 8'h00;
        end else begin
            if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
            if (mem_rd) mem_rdata <= bmem[mem_addr[7:0]];
        end
        if (mon_clr || !rst_n) begin
            n_we = 0; n_rd = 0; n_swe = 0; n_set = 0; n_clr = 0; n_slp = 0; n_oe = 0;
        end else begin
            if (mem_we) begin
                if (n_we < 8) begin wa[n_we] = mem_addr; wd[n_we] = mem_wdata; end
                n_we++;
            end
            if (mem_rd)    n_rd++;
            if (stat_we)   begin n_swe++; swd = stat_wdata; end
            if (wel_set)   n_set++;
            if (wel_clr)   n_clr++;
            if (sleep_req) n_slp++;
            if (miso_oe)   n_oe++;
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    logic m3 = 1'b0;

    task automatic sel_on(input logic mode3);
        m3 = mode3; sck = mode3; w(4); cs_n = 1'b0; w(HALF);
    endtask

    task automatic sel_off();
        if (!m3) begin sck = 1'b0; w(HALF); end
        cs_n = 1'b1; w(10); sck = 1'b0;
    endtask

    // One byte: fall, drive, wait, sample, rise, wait. oe_all reports drive on all bits.
    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
        oe_all = 1'b1;
        for (int b = 7; b >= 0; b--) begin
            sck = 1'b0; mosi = tx[b]; w(HALF);
            rx[b] = miso; oe_all &= miso_oe;
            sck = 1'b1; w(HALF);
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] r; logic o;
        xbyte(tx, r, o);
    endtask

    task automatic send_bits(input logic [7:0] tx, input int n);
        for (int b = 7; b > 7 - n; b--) begin
            sck = 1'b0; mosi = tx[b]; w(HALF); sck = 1'b1; w(HALF);
        end
    endtask

    task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a);
        send(op); send(a[23:16]); send(a[15:8]); send(a[7:0]);
    endtask

    task automatic rd_chk(input logic [7:0] exp, input string req);
        logic [7:0] r; logic o;
        xbyte(8'h00, r, o);
        chk(r == exp, req, r, exp);
        chk(o, req, o, 1);
    endtask

    task automatic t_reset();
        chk(!miso_oe && !mem_rd && !mem_we && !stat_we, "R13 strobes", {miso_oe, mem_rd, mem_we, stat_we}, 0);
        chk(!wel_set && !wel_clr && !sleep_req, "R13 pulses", {wel_set, wel_clr, sleep_req}, 0);
    endtask

    task automatic t_write_read_m0();
        clr_mon();
        sel_on(1'b0); cmd_addr(8'h02, 24'h000010);
        send(8'hA1); send(8'hB2); send(8'hC3); sel_off();
        chk(n_we == 3, "R6 write count", n_we, 3);
        chk(wa[0] == 18'h10 && wd[0] == 8'hA1, "R6 first commit", wd[0], 8'hA1);
        chk(wa[2] == 18'h12 && wd[2] == 8'hC3, "R5 increment", wa[2], 18'h12);
        chk(n_clr == 1, "R10 latch clear after write", n_clr, 1);
        clr_mon();
        sel_on(1'b0); cmd_addr(8'h03, 24'h000010);
        chk(n_oe == 0, "R12 no drive during command", n_oe, 0);
        rd_chk(8'hA1, "R4 read byte0"); rd_chk(8'hB2, "R4 read byte1");
        rd_chk(8'hC3, "R4 read byte2"); rd_chk(8'h13 ^ 8'h5A, "R4 read byte3");
        sel_off();
        chk(!miso_oe, "R12 drive off after deselect", miso_oe, 0);
        chk(n_clr == 0, "R10 no clear after read", n_clr, 0);
    endtask

    task automatic t_read_m3();
        sel_on(1'b1); cmd_addr(8'h03, 24'h000011);
        rd_chk(8'hB2, "R1 mode3 byte0"); rd_chk(8'hC3, "R1 mode3 byte1");
        sel_off();
    endtask

    task automatic t_addr_upper();
        sel_on(1'b0); cmd_addr(8'h03, 24'hFC0010);
        rd_chk(8'hA1, "R4 upper address bits dropped");
        sel_off();
    endtask

    task automatic t_wrap();
        clr_mon();
        sel_on(1'b0); cmd_addr(8'h02, 24'h03FFFF); send(8'h11); send(8'h22); sel_off();
        chk(wa[0] == 18'h3FFFF, "R5 top address", wa[0], 18'h3FFFF);
        chk(wa[1] == 18'h00000, "R5 wrap to zero", wa[1], 0);
        sel_on(1'b1); cmd_addr(8'h03, 24'h03FFFE);
        rd_chk(8'hFE ^ 8'h5A, "R5 read before top"); rd_chk(8'h11, "R5 read top");
        rd_chk(8'h22, "R5 read wrapped");
        sel_off();
    endtask

    task automatic t_fast();
        logic [7:0] r; logic o;
        sel_on(1'b0); cmd_addr(8'h0B, 24'h000010);
        clr_mon();
        xbyte(8'hFF, r, o);
        chk(n_oe == 0, "R7 no drive in dummy", n_oe, 0);
        rd_chk(8'hA1, "R7 fast byte0"); rd_chk(8'hB2, "R7 fast byte1");
        sel_off();
    endtask

    task automatic t_ident();
        logic [7:0] exp;
        sel_on(1'b1); send(8'h9F);
        for (int i = 0; i < 10; i++) begin
            exp = (i < 6) ? 8'h7F : (i == 6) ? 8'hC2 : (i == 7) ? 8'h25 : 8'h00;
            rd_chk(exp, "R8 identification");
        end
        sel_off();
    endtask

    task automatic t_status();
        sel_on(1'b0); send(8'h05);
        rd_chk(8'h4C, "R9 status read0"); rd_chk(8'h4C, "R9 status read1");
        sel_off();
        clr_mon();
        sel_on(1'b0); send(8'h01); send(8'h8C); send(8'h77); sel_off();
        chk(n_swe == 1 && swd == 8'h8C, "R9 status write once", n_swe, 1);
        chk(n_clr == 1, "R10 clear after status write", n_clr, 1);
        clr_mon(); stat_wr_allow = 1'b0;
        sel_on(1'b0); send(8'h01); send(8'h33); sel_off();
        chk(n_swe == 0 && n_clr == 0, "R9 status write refused", n_swe, 0);
        stat_wr_allow = 1'b1;
    endtask

    task automatic t_protect();
        clr_mon(); mem_wr_allow = 1'b0;
        sel_on(1'b0); cmd_addr(8'h02, 24'h000020); send(8'h99); sel_off();
        chk(n_we == 0 && n_clr == 0, "R6 write refused", n_we, 0);
        mem_wr_allow = 1'b1;
        sel_on(1'b0); cmd_addr(8'h03, 24'h000020); rd_chk(8'h20 ^ 8'h5A, "R6 refused byte kept"); sel_off();
    endtask

    task automatic t_partial();
        clr_mon();
        sel_on(1'b0); cmd_addr(8'h02, 24'h000030); send(8'h5D); send_bits(8'hF0, 4); sel_off();
        chk(n_we == 1, "R6 partial byte dropped", n_we, 1);
        sel_on(1'b0); cmd_addr(8'h03, 24'h000030);
        rd_chk(8'h5D, "R6 full byte"); rd_chk(8'h31 ^ 8'h5A, "R6 partial untouched");
        sel_off();
    endtask

    task automatic t_unknown();
        clr_mon();
        sel_on(1'b0); send(8'hA5); send(8'h03); send(8'h00); send(8'h05); sel_off();
        chk(n_oe == 0, "R12 unknown command no drive", n_oe, 0);
        chk(n_rd == 0 && n_we == 0 && n_swe == 0, "R3 unknown command inert", n_rd + n_we, 0);
    endtask

    task automatic t_one_op();
        clr_mon();
        sel_on(1'b0); send(8'h06);
        chk(n_set == 1, "R10 latch set", n_set, 1);
        cmd_addr(8'h02, 24'h000040); send(8'h55); sel_off();
        chk(n_we == 0 && n_set == 1 && n_clr == 0, "R3 second op ignored", n_we, 0);
        clr_mon();
        sel_on(1'b1); send(8'h04); sel_off();
        chk(n_clr == 1 && n_set == 0, "R10 latch clear", n_clr, 1);
        chk(n_oe == 0, "R2 latch codes no drive", n_oe, 0);
    endtask

    task automatic t_sleep();
        clr_mon();
        sel_on(1'b0); send(8'hB9); w(6);
        chk(n_slp == 0, "R11 no sleep while selected", n_slp, 0);
        sel_off();
        chk(n_slp == 1, "R11 sleep at deselect", n_slp, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        w(6); t_reset(); rst_n = 1'b1; w(6);
        t_reset();
        t_write_read_m0();
        t_read_m3();
        t_addr_upper();
        t_wrap();
        t_fast();
        t_ident();
        t_status();
        t_protect();
        t_partial();
        t_unknown();
        t_one_op();
        t_sleep();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule